// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers the interrupt sources of a graphics engine's tiling front end and renderer and presents them to a processor as one interrupt line behind a small register window. Two of the sources are single-cycle completion events: the tiler finishing its flush of a job, and the renderer finishing a frame. Each is caught in a sticky status bit. The third source is the tiler running short of spill memory. This is a standing condition and not an event. The tiler raises a request, and the controller holds the condition until software supplies a fresh spill region.

Software sees a status word that it clears by writing ones. It also sees two write-one registers, one that turns interrupts on and one that turns them off, and both of these read back the same enable mask. A pair of registers carries the spill region's base and size to the tiler. Writing the size completes the hand-over and releases the memory condition. After that, a write-one clear of the memory status bit finally sticks. The interrupt output is a registered OR of the enabled pending bits.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset, status, enable mask, spill base, spill size, read data, `spill_load` and `irq` are all 0.
- R2: Status bit 0 is frame done, bit 1 is flush done and bit 2 is spill memory. A pulse on `ev_frame_done` or `ev_flush_done` sets its bit at that clock edge. Writing a 1 to that bit at address 0 clears it, and writing a 0 leaves it as it was.
- R3: When an event pulse and a write-one clear of the same bit fall in the same cycle, the bit stays set.
- R4: A write to address 1 sets each enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R5: A write to address 2 clears each enable bit whose data bit is 1. Data bits that are 0 leave their enable bits unchanged.
- R6: Reads of address 1 and of address 2 both return the enable mask, and bits 31 to 3 read 0. Read data appears on `bus_rdata` in the cycle after the read request.
- R7: A cycle of `spill_req` latches a memory shortage. While the shortage is held, status bit 2 is set again every cycle, so a write-one clear of bit 2 does not remove it.
- R8: Writes to address 3 (spill base) and address 4 (spill size) are stored, read back and driven on `spill_base` and `spill_size`. A size write pulses `spill_load` for one cycle and releases the held shortage, after which a write-one clear of bit 2 removes it.
- R9: `irq` goes high one cycle after status AND enable becomes nonzero, and goes low one cycle after it becomes zero.
- R10: Addresses 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| ev_frame_done | input | 1 | Renderer frame-complete pulse |
| ev_flush_done | input | 1 | Tiler flush-complete pulse |
| spill_req | input | 1 | Tiler asks for new spill memory |
| spill_base | output | 32 | Spill region base address |
| spill_size | output | 32 | Spill region size in bytes |
| spill_load | output | 1 | One-cycle strobe when a new region is handed over |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions can fall in the same cycle. A completion event can arrive in the cycle where software writes a one to clear that same status bit, and a spill request can arrive alongside a status clear that it must override. The bench provokes the first case by driving an event pulse in the cycle of a status write that targets the same bit. It then reads status back and expects the bit to remain set. For the second case it holds a shortage and clears bit 2, then checks that bit 2 stays set until the size register has been written.

// File: rtl/gic_pkg.sv
// Shared constants for the graphics interrupt controller.
// Assumes word addressing on a 3-bit register bus.
package gic_pkg;
    localparam int NSRC      = 3;
    localparam int SRC_FRAME = 0;
    localparam int SRC_FLUSH = 1;
    localparam int SRC_SPILL = 2;

    localparam int OFS_STATUS = 0;
    localparam int OFS_EN_SET = 1;
    localparam int OFS_EN_CLR = 2;
    localparam int OFS_BASE   = 3;
    localparam int OFS_SIZE   = 4;
endpackage

// File: rtl/irq_status_bit.sv
// One sticky status bit with write-one-to-clear.
// Assumes set_i and clr_i are single-cycle qualified strobes; set wins.
module irq_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold state, set on event, clear on acknowledge; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/irq_enable_mask.sv
// Enable mask updated by separate write-one set and write-one clear masks.
// Assumes set and clear never arrive in the same cycle (distinct addresses).
module irq_enable_mask #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] mask_o
);
    // Apply set bits then clear bits; zero bits leave the mask alone.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_o <= '0;
        else        mask_o <= (mask_o | set_mask) & ~clr_mask;
    end
endmodule

// File: rtl/spill_mem_regs.sv
// Spill-memory base/size registers and the held shortage condition.
// Assumes a size write completes a hand-over; a request in the same cycle wins.
module spill_mem_regs #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_base,
    input  logic          wr_size,
    input  logic [DW-1:0] wdata,
    input  logic          req_i,
    output logic [DW-1:0] base_o,
    output logic [DW-1:0] size_o,
    output logic          load_o,
    output logic          hold_o
);
    // Store base and size words when addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            size_o <= '0;
        end else begin
            if (wr_base) base_o <= wdata;
            if (wr_size) size_o <= wdata;
        end
    end

    // One-cycle strobe accompanying a newly stored size.
    always_ff @(posedge clk) begin
        if (!rst_n) load_o <= 1'b0;
        else        load_o <= wr_size;
    end

    // Shortage latched on request, released by a size write.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_o <= 1'b0;
        else if (req_i)   hold_o <= 1'b1;
        else if (wr_size) hold_o <= 1'b0;
    end
endmodule

// File: rtl/gfx_irq_ctrl.sv
// Interrupt controller for a graphics engine: two latched completion
// events, one held spill-memory shortage, write-one enable/disable,
// registered read data and a registered interrupt line.
// Assumes DATA_W >= number of sources and ADDR_W >= 3.
module gfx_irq_ctrl #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_frame_done,
    input  logic              ev_flush_done,
    input  logic              spill_req,
    output logic [DATA_W-1:0] spill_base,
    output logic [DATA_W-1:0] spill_size,
    output logic              spill_load,
    output logic              irq
);
    import gic_pkg::*;

    localparam int N = NSRC;

    logic          wr_stat, wr_ens, wr_enc, wr_base, wr_size, rd_req;
    logic [N-1:0]  src_set;
    logic [N-1:0]  status_q;
    logic [N-1:0]  enable_q;
    logic          spill_hold;

    // Decode the register bus into per-register strobes.
    always_comb begin
        wr_stat = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
        wr_ens  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_EN_SET));
        wr_enc  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_EN_CLR));
        wr_base = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_BASE));
        wr_size = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_SIZE));
        rd_req  = bus_en && !bus_we;
    end

    // Gather the set sources in status bit order.
    always_comb begin
        src_set            = '0;
        src_set[SRC_FRAME] = ev_frame_done;
        src_set[SRC_FLUSH] = ev_flush_done;
        src_set[SRC_SPILL] = spill_hold;
    end

    // One sticky status cell per source.
    for (genvar i = 0; i < N; i++) begin : g_stat
        irq_status_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (src_set[i]),
            .clr_i (wr_stat && bus_wdata[i]),
            .q_o   (status_q[i])
        );
    end

    irq_enable_mask #(.N(N)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (wr_ens ? bus_wdata[N-1:0] : '0),
        .clr_mask (wr_enc ? bus_wdata[N-1:0] : '0),
        .mask_o   (enable_q)
    );

    spill_mem_regs #(.DW(DATA_W)) u_spill (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_base (wr_base),
        .wr_size (wr_size),
        .wdata   (bus_wdata),
        .req_i   (spill_req),
        .base_o  (spill_base),
        .size_o  (spill_size),
        .load_o  (spill_load),
        .hold_o  (spill_hold)
    );

    // Registered read mux; unmapped addresses return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_req) begin
            case (bus_addr)
                ADDR_W'(OFS_STATUS): bus_rdata <= DATA_W'(status_q);
                ADDR_W'(OFS_EN_SET),
                ADDR_W'(OFS_EN_CLR): bus_rdata <= DATA_W'(enable_q);
                ADDR_W'(OFS_BASE):   bus_rdata <= spill_base;
                ADDR_W'(OFS_SIZE):   bus_rdata <= spill_size;
                default:             bus_rdata <= '0;
            endcase
        end
    end

    // Registered interrupt request from enabled pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status_q & enable_q);
    end
endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
// Property checker for gfx_irq_ctrl, bound to every instance.
// Assumes the default 3-bit address and three sources.
module gfx_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        ev_frame_done,
    input logic        spill_req,
    input logic        irq,
    input logic [2:0]  st,
    input logic [2:0]  en,
    input logic        hold
);
    logic wr_any;
    assign wr_any = bus_en && bus_we;

    p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == 3'd0 && bus_wdata[0] && !ev_frame_done) |=> !st[0]);

    p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_done |=> st[0]);

    p_enable_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == 3'd1 && bus_wdata[1]) |=> en[1]);

    p_enable_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == 3'd2 && bus_wdata[1]) |=> !en[1]);

    p_spill_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> st[2]);

    p_size_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == 3'd4 && !spill_req) |=> !hold);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(st & en)));
endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_en        (bus_en),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .ev_frame_done (ev_frame_done),
    .spill_req     (spill_req),
    .irq           (irq),
    .st            (status_q),
    .en            (enable_q),
    .hold          (spill_hold)
);

// File: tb/gfx_irq_ctrl_test.sv
// Directed bench for gfx_irq_ctrl: one task per scenario.
module gfx_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_frame_done = 1'b0, ev_flush_done = 1'b0, spill_req = 1'b0;
    logic [31:0] spill_base, spill_size;
    logic        spill_load, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gfx_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_frame_done(ev_frame_done), .ev_flush_done(ev_flush_done),
        .spill_req(spill_req), .spill_base(spill_base), .spill_size(spill_size),
        .spill_load(spill_load), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Write cycle, optionally with event pulses in the same cycle.
    task automatic wr_ev(input logic [2:0] a, input logic [31:0] d,
                         input logic fr, input logic fl);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        ev_frame_done = fr; ev_flush_done = fl;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; ev_frame_done = 1'b0; ev_flush_done = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_ev(a, d, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic fr, input logic fl);
        @(negedge clk);
        ev_frame_done = fr; ev_flush_done = fl;
        @(negedge clk);
        ev_frame_done = 1'b0; ev_flush_done = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 spill_load", 32'(spill_load), 0);
        chk("R1 base", spill_base, 0);
        chk("R1 size", spill_size, 0);
        chk("R1 rdata", bus_rdata, 0);
        rd(3'd0, d); chk("R1 status", d, 0);
        rd(3'd1, d); chk("R1 enable", d, 0);
    endtask

    task automatic t_events;
        logic [31:0] d;
        pulse(1'b1, 1'b0);
        rd(3'd0, d); chk("R2 frame sets bit0", d, 32'h1);
        pulse(1'b0, 1'b1);
        rd(3'd0, d); chk("R2 flush sets bit1", d, 32'h3);
        wr(3'd0, 32'h0);
        rd(3'd0, d); chk("R2 zero write keeps", d, 32'h3);
        wr(3'd0, 32'h2);
        rd(3'd0, d); chk("R2 clear bit1 only", d, 32'h1);
        wr(3'd0, 32'h1);
        rd(3'd0, d); chk("R2 clear bit0", d, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        pulse(1'b1, 1'b1);
        wr_ev(3'd0, 32'h3, 1'b1, 1'b0);
        rd(3'd0, d); chk("R3 event beats clear", d, 32'h1);
        wr(3'd0, 32'h1);
        rd(3'd0, d); chk("R3 later clear", d, 32'h0);
    endtask

    task automatic t_enables;
        logic [31:0] d;
        wr(3'd1, 32'h5);
        rd(3'd1, d); chk("R4 set 101", d, 32'h5);
        wr(3'd1, 32'h2);
        rd(3'd1, d); chk("R4 zeros ignored", d, 32'h7);
        wr(3'd2, 32'h4);
        rd(3'd2, d); chk("R5 clear bit2", d, 32'h3);
        rd(3'd1, d); chk("R6 both read mask", d, 32'h3);
        wr(3'd2, 32'h0);
        rd(3'd2, d); chk("R5 zeros ignored", d, 32'h3);
        wr(3'd1, 32'hFFFF_FFF8);
        rd(3'd1, d); chk("R6 upper bits zero", d, 32'h3);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd1, d); chk("R5 clear all", d, 32'h0);
    endtask

    task automatic t_irq;
        wr(3'd1, 32'h2);
        @(negedge clk); ev_flush_done = 1'b1;
        @(negedge clk); ev_flush_done = 1'b0;
        chk("R9 irq not yet", 32'(irq), 0);
        @(negedge clk);
        chk("R9 irq one cycle later", 32'(irq), 1);
        wr(3'd0, 32'h2);
        chk("R9 irq still registered", 32'(irq), 1);
        @(negedge clk);
        chk("R9 irq falls", 32'(irq), 0);
        pulse(1'b1, 1'b0);
        @(negedge clk);
        chk("R9 disabled source quiet", 32'(irq), 0);
        wr(3'd0, 32'h1);
        wr(3'd2, 32'h2);
    endtask

    task automatic t_spill;
        logic [31:0] d;
        @(negedge clk); spill_req = 1'b1;
        @(negedge clk); spill_req = 1'b0;
        rd(3'd0, d); chk("R7 shortage shown", d, 32'h4);
        wr(3'd0, 32'h4);
        rd(3'd0, d); chk("R7 clear does not stick", d, 32'h4);
        wr(3'd3, 32'h0010_0000);
        rd(3'd3, d); chk("R8 base readback", d, 32'h0010_0000);
        chk("R8 base port", spill_base, 32'h0010_0000);
        chk("R8 no load on base", 32'(spill_load), 0);
        wr(3'd4, 32'h0004_0000);
        chk("R8 load strobe", 32'(spill_load), 1);
        @(negedge clk);
        chk("R8 load one cycle", 32'(spill_load), 0);
        chk("R8 size port", spill_size, 32'h0004_0000);
        rd(3'd4, d); chk("R8 size readback", d, 32'h0004_0000);
        wr(3'd0, 32'h4);
        rd(3'd0, d); chk("R8 clear after load", d, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'hFFFF_FFFF);
            rd(3'(a), d); chk("R10 unmapped reads 0", d, 0);
        end
        rd(3'd0, d); chk("R10 status untouched", d, 0);
        rd(3'd1, d); chk("R10 enable untouched", d, 0);
        rd(3'd3, d); chk("R10 base untouched", d, 32'h0010_0000);
        rd(3'd4, d); chk("R10 size untouched", d, 32'h0004_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_events;
        t_collision;
        t_enables;
        t_irq;
        t_spill;
        t_unmapped;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule